// File: doc/BRIEF.md
# Digital PWM Channel with Preset Sync

This block is one pulse-width modulation channel with two complementary outputs, A and B, both timed from a single up-counting period counter. The counter restarts when the channel is switched on, when an external sync pulse arrives while the channel is configured as a slave, and when it reaches the programmed period value. A preset option makes the switch-on and sync restarts load a programmable count instead of zero, so that several channels sharing one sync can run with staggered phases. The wrap at the period value always returns to zero.

The duty value is taken either from a local configuration input or from an external filter output, chosen by a select bit. The chosen value is captured only when a new period begins. A cycle-by-cycle current-limit input can cut either output short for the rest of the period. Each output has its own blanking enable, which hides the current-limit input during a window at the start of the period so that switching noise does not trip it. Each output also has an invert bit and a fault-level bit. The fault level is driven, without inversion, whenever the channel is switched off.

All configuration inputs are static while in use. Both outputs are registered and show the counter state of the previous cycle.

Top module: `pwmch_top`

## Requirements
- R1: While `rst` is high, and in the cycle after it, both outputs are 0 whatever the invert and fault-level bits are.
- R2: While `ch_en` is 0, and in the first cycle after it rises, each output equals its fault-level bit (`fpol_a`, `fpol_b`), with no inversion applied.
- R3: With the channel running, the counter rises by one each cycle. From any count greater than or equal to `period_val` it goes to zero, so an undisturbed period lasts `period_val`+1 cycles.
- R4: On the cycle `ch_en` is first seen high, the counter loads `preset_val` if `preset_on` is 1, or zero if it is 0.
- R5: A `sync_pulse` while running with `slave_mode` = 1 loads the counter as in R4. With `slave_mode` = 0 it has no effect.
- R6: Before inversion, output A is 1 while the counter is below the latched duty and 0 otherwise, and output B is the complement of A. Each output shows the count of the cycle before it.
- R7: The latched duty is `filt_duty` when `filt_sel` = 1 and `reg_duty` when `filt_sel` = 0. It is captured only at the start of a period (an R4/R5 load or an R3 wrap), and changes at other times have no effect until the next start.
- R8: When running, `inv_a` and `inv_b` each invert their own output pin, after fault gating has been applied.
- R9: A sampled `ilim_trip` forces both outputs to their inactive level (0 before inversion) from that cycle's output to the end of the period. The exception is an output whose blank bit (`blank_on_a`/`blank_on_b`) is 1 while the counter is at or below `blank_end`: for that output the trip is ignored. The kill clears when the next period starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ch_en | input | 1 | Channel enable |
| slave_mode | input | 1 | Accept external sync pulses |
| sync_pulse | input | 1 | Single-cycle sync request |
| preset_on | input | 1 | Load preset instead of zero on enable and sync |
| preset_val | input | CW | Preset count |
| period_val | input | CW | Terminal count of the period |
| filt_sel | input | 1 | 1 selects the filter duty input |
| reg_duty | input | CW | Local duty value |
| filt_duty | input | CW | Duty from the external filter |
| ilim_trip | input | 1 | Cycle-by-cycle current-limit trip |
| blank_end | input | CW | Last count inside the blanking window |
| blank_on_a | input | 1 | Blanking enable for output A |
| blank_on_b | input | 1 | Blanking enable for output B |
| inv_a | input | 1 | Invert output A |
| inv_b | input | 1 | Invert output B |
| fpol_a | input | 1 | Level of A while disabled |
| fpol_b | input | 1 | Level of B while disabled |
| out_a | output | 1 | PWM output A |
| out_b | output | 1 | PWM output B |

## Verification
On every cycle the assertions check the counter: its wrap to zero, its restart value on enable and on an accepted sync, and that it keeps counting when a sync arrives without slave mode. They also check that the duty register holds between period starts and loads the right source at one, the reset and disabled output levels, the A/B complement, and that a latched kill holds the outputs inactive. Only the bench scenarios can show that whole waveforms come out right. These include staggered preset starts, duty changes made mid-period that take effect at the next period, trips placed inside and outside the blanking window, and every invert combination. The bench shows this by comparing both pins against a behavioural model on every cycle.

// File: rtl/pwmch_pkg.sv
package pwmch_pkg;
  localparam int unsigned NOUT = 2;

  typedef enum logic [1:0] {
    ACT_ZERO = 2'd0,
    ACT_LOAD = 2'd1,
    ACT_WRAP = 2'd2,
    ACT_STEP = 2'd3
  } cnt_act_e;
endpackage

// File: rtl/pwmch_counter.sv
module pwmch_counter
  import pwmch_pkg::*;
#(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ch_en,
  input  logic          slave_mode,
  input  logic          sync_pulse,
  input  logic          preset_on,
  input  logic [CW-1:0] preset_val,
  input  logic [CW-1:0] period_val,
  output logic [CW-1:0] cnt,
  output logic          run,
  output logic          period_start
);
  logic          en_q;
  logic          en_rise;
  logic          sync_hit;
  logic [CW-1:0] load_val;
  cnt_act_e      act;

  assign run      = ch_en & en_q;
  assign en_rise  = ch_en & ~en_q;
  assign sync_hit = run & slave_mode & sync_pulse;
  assign load_val = preset_on ? preset_val : '0;

  always_comb begin
    if (!ch_en)                     act = ACT_ZERO;
    else if (en_rise || sync_hit)   act = ACT_LOAD;
    else if (cnt >= period_val)     act = ACT_WRAP;
    else                            act = ACT_STEP;
  end

  assign period_start = (act == ACT_LOAD) || (act == ACT_WRAP);

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q <= 1'b0;
      cnt  <= '0;
    end else begin
      en_q <= ch_en;
      case (act)
        ACT_ZERO: cnt <= '0;
        ACT_LOAD: cnt <= load_val;
        ACT_WRAP: cnt <= '0;
        default:  cnt <= cnt + 1'b1;
      endcase
    end
  end

  // R3: wrap to zero at or past the period value
  p_wrap_r3: assert property (@(posedge clk) disable iff (rst)
    (run && !(slave_mode && sync_pulse) && ch_en && (cnt >= period_val)) |=> (cnt == '0));

  // R4: enable rise loads preset or zero
  p_enload_r4: assert property (@(posedge clk) disable iff (rst)
    (ch_en && !en_q) |=> (cnt == ($past(preset_on) ? $past(preset_val) : '0)));

  // R5: accepted sync loads preset or zero
  p_sync_r5: assert property (@(posedge clk) disable iff (rst)
    (run && slave_mode && sync_pulse) |=> (cnt == ($past(preset_on) ? $past(preset_val) : '0)));

  // R5: sync without slave mode leaves the count stepping
  p_nosync_r5: assert property (@(posedge clk) disable iff (rst)
    (run && !slave_mode && sync_pulse && (cnt < period_val)) |=> (cnt == $past(cnt) + 1'b1));
endmodule

// File: rtl/pwmch_duty.sv
module pwmch_duty #(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          period_start,
  input  logic          filt_sel,
  input  logic [CW-1:0] reg_duty,
  input  logic [CW-1:0] filt_duty,
  output logic [CW-1:0] duty_q
);
  logic [CW-1:0] duty_src;

  assign duty_src = filt_sel ? filt_duty : reg_duty;

  always_ff @(posedge clk) begin
    if (rst)               duty_q <= '0;
    else if (period_start) duty_q <= duty_src;
  end

  // R7: duty holds between period starts
  p_duty_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !period_start |=> $stable(duty_q));

  // R7: source chosen by the select bit at a period start
  p_duty_load_r7: assert property (@(posedge clk) disable iff (rst)
    period_start |=> (duty_q == ($past(filt_sel) ? $past(filt_duty) : $past(reg_duty))));
endmodule

// File: rtl/pwmch_outgen.sv
module pwmch_outgen
  import pwmch_pkg::*;
#(
  parameter int unsigned CW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            run,
  input  logic            period_start,
  input  logic [CW-1:0]   cnt,
  input  logic [CW-1:0]   duty_q,
  input  logic            ilim_trip,
  input  logic [CW-1:0]   blank_end,
  input  logic [NOUT-1:0] blank_on,
  input  logic [NOUT-1:0] inv,
  input  logic [NOUT-1:0] fpol,
  output logic [NOUT-1:0] out_q
);
  logic            in_window;
  logic            above_a;
  logic [NOUT-1:0] raw;
  logic [NOUT-1:0] kill_now;
  logic [NOUT-1:0] kill_q;

  assign in_window = (cnt <= blank_end);
  assign above_a   = (cnt < duty_q);
  assign raw[0]    = above_a;
  assign raw[1]    = ~above_a;

  for (genvar i = 0; i < NOUT; i++) begin : g_out
    assign kill_now[i] = run & ilim_trip & ~(blank_on[i] & in_window);

    always_ff @(posedge clk) begin
      if (rst || !run || period_start) kill_q[i] <= 1'b0;
      else                             kill_q[i] <= kill_q[i] | kill_now[i];
    end

    always_ff @(posedge clk) begin
      if (rst)       out_q[i] <= 1'b0;
      else if (!run) out_q[i] <= fpol[i];
      else           out_q[i] <= (raw[i] & ~(kill_q[i] | kill_now[i])) ^ inv[i];
    end

    // R2: disabled output shows the fault level, uninverted
    p_dis_r2: assert property (@(posedge clk) disable iff (rst)
      !run |=> (out_q[i] == $past(fpol[i])));

    // R9: a latched kill keeps the output inactive
    p_kill_r9: assert property (@(posedge clk) disable iff (rst)
      (run && kill_q[i]) |=> (out_q[i] == $past(inv[i])));
  end

  // R1: reset clears both outputs
  p_rst_r1: assert property (@(posedge clk)
    rst |=> (out_q == '0));

  // R6: without a kill, B is the complement of A before inversion
  p_comp_r6: assert property (@(posedge clk) disable iff (rst)
    (run && ((kill_q | kill_now) == '0))
      |=> ((out_q[0] ^ $past(inv[0])) != (out_q[1] ^ $past(inv[1]))));
endmodule

// File: rtl/pwmch_top.sv
module pwmch_top
  import pwmch_pkg::*;
#(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ch_en,
  input  logic          slave_mode,
  input  logic          sync_pulse,
  input  logic          preset_on,
  input  logic [CW-1:0] preset_val,
  input  logic [CW-1:0] period_val,
  input  logic          filt_sel,
  input  logic [CW-1:0] reg_duty,
  input  logic [CW-1:0] filt_duty,
  input  logic          ilim_trip,
  input  logic [CW-1:0] blank_end,
  input  logic          blank_on_a,
  input  logic          blank_on_b,
  input  logic          inv_a,
  input  logic          inv_b,
  input  logic          fpol_a,
  input  logic          fpol_b,
  output logic          out_a,
  output logic          out_b
);
  logic [CW-1:0]   cnt;
  logic            run;
  logic            period_start;
  logic [CW-1:0]   duty_q;
  logic [NOUT-1:0] outs;

  pwmch_counter #(.CW(CW)) u_cnt (
    .clk(clk), .rst(rst), .ch_en(ch_en), .slave_mode(slave_mode),
    .sync_pulse(sync_pulse), .preset_on(preset_on), .preset_val(preset_val),
    .period_val(period_val), .cnt(cnt), .run(run), .period_start(period_start)
  );

  pwmch_duty #(.CW(CW)) u_duty (
    .clk(clk), .rst(rst), .period_start(period_start), .filt_sel(filt_sel),
    .reg_duty(reg_duty), .filt_duty(filt_duty), .duty_q(duty_q)
  );

  pwmch_outgen #(.CW(CW)) u_out (
    .clk(clk), .rst(rst), .run(run), .period_start(period_start),
    .cnt(cnt), .duty_q(duty_q), .ilim_trip(ilim_trip), .blank_end(blank_end),
    .blank_on({blank_on_b, blank_on_a}), .inv({inv_b, inv_a}),
    .fpol({fpol_b, fpol_a}), .out_q(outs)
  );

  assign out_a = outs[0];
  assign out_b = outs[1];
endmodule

// File: tb/sim_pwmch_top.sv
module sim_pwmch_top;
  localparam int CW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ch_en = 0, slave_mode = 0, sync_pulse = 0, preset_on = 0;
  logic [CW-1:0] preset_val = 0, period_val = 9, reg_duty = 4, filt_duty = 0, blank_end = 0;
  logic filt_sel = 0, ilim_trip = 0, blank_on_a = 0, blank_on_b = 0;
  logic inv_a = 0, inv_b = 0, fpol_a = 0, fpol_b = 0;
  logic out_a, out_b;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;
  string tag = "R1";

  // reference model state
  int m_cnt = 0, m_duty = 0;
  bit m_en_q = 0;
  bit m_kill[2] = '{0, 0};
  bit m_out[2] = '{0, 0};

  always #2.5 clk = ~clk;

  pwmch_top #(.CW(CW)) u0 (
    .clk(clk), .rst(rst), .ch_en(ch_en), .slave_mode(slave_mode),
    .sync_pulse(sync_pulse), .preset_on(preset_on), .preset_val(preset_val),
    .period_val(period_val), .filt_sel(filt_sel), .reg_duty(reg_duty),
    .filt_duty(filt_duty), .ilim_trip(ilim_trip), .blank_end(blank_end),
    .blank_on_a(blank_on_a), .blank_on_b(blank_on_b), .inv_a(inv_a), .inv_b(inv_b),
    .fpol_a(fpol_a), .fpol_b(fpol_b), .out_a(out_a), .out_b(out_b)
  );

  always @(posedge clk) begin
    bit run, rise, start, wrap, a_hi;
    bit bon[2], iv[2], fp[2], kn[2];
    bon = '{blank_on_a, blank_on_b};
    iv  = '{inv_a, inv_b};
    fp  = '{fpol_a, fpol_b};
    if (rst) begin
      m_cnt = 0; m_duty = 0; m_en_q = 0;
      m_kill = '{0, 0}; m_out = '{0, 0};
    end else begin
      run   = ch_en && m_en_q;
      rise  = ch_en && !m_en_q;
      start = rise || (run && slave_mode && sync_pulse);
      wrap  = run && !start && (m_cnt >= int'(period_val));
      a_hi  = m_cnt < m_duty;
      for (int i = 0; i < 2; i++) begin
        kn[i] = run && ilim_trip && !(bon[i] && m_cnt <= int'(blank_end));
        if (!run) m_out[i] = fp[i];
        else m_out[i] = (((i == 0) ? a_hi : !a_hi) && !(m_kill[i] || kn[i])) ^ iv[i];
        if (!run || start || wrap) m_kill[i] = 0;
        else m_kill[i] = m_kill[i] || kn[i];
      end
      if (start || wrap) m_duty = filt_sel ? int'(filt_duty) : int'(reg_duty);
      if (!ch_en) m_cnt = 0;
      else if (start) m_cnt = preset_on ? int'(preset_val) : 0;
      else if (wrap) m_cnt = 0;
      else m_cnt = (m_cnt + 1) % (1 << CW);
      m_en_q = ch_en;
    end
  end

  task automatic compare();
    compared++;
    if (out_a !== m_out[0] || out_b !== m_out[1]) begin
      mismatched++;
      $display("FAIL %s: out_a/out_b=%b%b expected %b%b at %0t",
               tag, out_a, out_b, m_out[0], m_out[1], $time);
    end
  endtask

  task automatic step(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      compare();
    end
  endtask

  task automatic pulse_sync();
    sync_pulse = 1; step(1); sync_pulse = 0;
  endtask

  task automatic pulse_trip();
    ilim_trip = 1; step(1); ilim_trip = 0;
  endtask

  initial begin
    // R1: reset with invert and fault bits set
    tag = "R1 reset"; inv_a = 1; inv_b = 1; fpol_a = 1; fpol_b = 1;
    step(4);
    rst = 0; step(1);
    inv_a = 0; inv_b = 0;
    // R2: disabled outputs follow fault level, not inverted
    tag = "R2 disabled"; fpol_a = 1; fpol_b = 0; inv_a = 1; step(4);
    fpol_a = 0; fpol_b = 1; step(3);
    inv_a = 0;
    // R3/R6: free-running, no preset
    tag = "R3 R6 run"; ch_en = 1; step(35);
    period_val = 5; reg_duty = 2; step(20);
    reg_duty = 0; step(14);
    reg_duty = 8; step(14);
    reg_duty = 3;
    // R4: restart with preset, including a preset above the period
    tag = "R4 preset"; ch_en = 0; step(3);
    preset_on = 1; preset_val = 4; ch_en = 1; step(15);
    ch_en = 0; step(2); preset_val = 9; ch_en = 1; step(12);
    ch_en = 0; step(2); preset_on = 0; ch_en = 1; step(10);
    // R5: sync, with and without slave mode
    tag = "R5 sync"; period_val = 11; reg_duty = 5; preset_on = 1; preset_val = 3;
    step(6); pulse_sync(); step(5);
    slave_mode = 1; pulse_sync(); step(7); pulse_sync(); step(14);
    preset_on = 0; pulse_sync(); step(9);
    slave_mode = 0; pulse_sync(); step(14);
    // R7: duty source and period-boundary latching
    tag = "R7 duty"; step(3); reg_duty = 9; step(13);
    filt_duty = 2; filt_sel = 1; step(4); filt_duty = 7; step(20);
    filt_sel = 0; step(15);
    // R8: invert combinations
    tag = "R8 invert"; inv_a = 1; step(13); inv_b = 1; step(13);
    inv_a = 0; step(13); inv_b = 0;
    // R9: current-limit trips and blanking
    tag = "R9 trip"; reg_duty = 8; blank_end = 3; step(14);
    step(6); pulse_trip(); step(15);
    step(1); pulse_trip(); step(14);
    blank_on_a = 1; step(1); pulse_trip(); step(13);
    step(7); pulse_trip(); step(12);
    blank_on_b = 1; inv_a = 1; step(2); pulse_trip(); step(12);
    ilim_trip = 1; step(26); ilim_trip = 0; step(14);
    inv_a = 0;
    // R2 again: disable while running drives fault levels
    tag = "R2 disable"; fpol_a = 1; fpol_b = 1; ch_en = 0; step(6);
    // R1 again: reset while enabled
    tag = "R1 rerun"; ch_en = 1; step(8); rst = 1; step(3); rst = 0; step(10);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: timeout actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule